// File: doc/BRIEF.md
# General-Purpose Timer with Postscaler and Event Capture

This block is a 32-bit timer for a chip's peripheral space. Software programs a control word, a load value and an interrupt-clear strobe through a simple register write port, and reads back the control word, the live count and a captured count through a combinational read port. The counter advances once for each pulse on one of four tick-enable inputs. All four inputs are single-cycle enables in the system clock domain. It counts up or down, either wrapping freely over the full 32-bit range or reloading from the load value at the end of each period.

An 8-bit postscaler counts timer periods. When interrupts are taken from the postscaler, the interrupt line goes high only once the programmed number of periods has elapsed, and a compare flag in the control word records that event. When interrupts are taken from the timer, every period end raises the line. One of eighteen event inputs can also be chosen to latch the running count into a read-only capture register on its rising edge, after two synchronising flops.

Register map (word address on `wr_addr`/`rd_addr`): 0 load value, 1 live count (read only), 2 control word, 3 interrupt clear (write only, reads 0), 4 capture value (read only).

Top module: `gp_timer_pcap`

## Requirements
- R1: After reset the control word reads 0x01000000, the count and the capture register read 0, and `irq` is low.
- R2: Writing 0 to control bits [31:24] stores a postscaler value of 1. Reading control bits [31:24] returns the current postscaler count, not the written value. Bits 22:20, 11 and 5:0 read as 0.
- R3: A write to the load register (address 1 reads the count) sets both the load value and the count. The count changes only on a cycle where control bit 7 (run) is set and the tick input chosen by control bits 10:9 (index 0 to 3) is high.
- R4: With control bit 6 clear (free-running), counting up (bit 8 = 1) wraps from 0xFFFFFFFF to 0, and counting down (bit 8 = 0) wraps from 0 to 0xFFFFFFFF. Each wrap is a period end.
- R5: With control bit 6 set (periodic), counting down reloads the load value on a tick at 0, and counting up returns to 0 on a tick at the load value. Each of these is a period end.
- R6: With control bit 18 clear, every period end sets `irq` on the following clock edge.
- R7: With control bits 23 and 18 set, the postscaler count steps down by one at each period end. At the period end that finds it at 1, `irq` and the compare flag (control bit 19) are set and the count restarts from the programmed value.
- R8: Any write to address 3 clears `irq` and the compare flag and restarts the postscaler count from the programmed value. A period end that sets `irq` in the same cycle takes precedence.
- R9: With control bit 17 set, a rising edge on `evt_in[i]`, where i is the index in control bits 16:12, stores the count into the capture register (address 4) two to three cycles after the edge.
- R10: No capture happens when control bit 17 is clear, when the event index is 18 or more, or when an event input that is not selected toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |
| tick_in | input | 4 | Tick-enable inputs, chosen by control bits 10:9 |
| evt_in | input | 18 | Asynchronous capture event inputs |
| irq | output | 1 | Pending interrupt, level |

## Verification
On every cycle the assertions check the reset values and the rule that the postscaler value and count are never zero. They also check that the count holds while the timer is stopped, that a down-step subtracts exactly one, that a timer-sourced period end raises `irq`, that a clear without a competing period end drops both `irq` and the flag, and that the capture register holds while capture is disabled. Only the bench scenarios can show the full sequences: wrap and reload points in each direction, that tick inputs which are not selected are ignored, the exact period on which the postscaler fires, the two-flop capture latency, and that an out-of-range event index never captures.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int REG_W  = 32;
    localparam int PS_W   = 8;
    localparam int SEL_W  = 5;
    localparam int TSRC_N = 4;
    localparam int TSEL_W = $clog2(TSRC_N);
    localparam int ADDR_W = 3;
    localparam int EVT_N  = 18;

    typedef enum logic [ADDR_W-1:0] {
        A_LOAD  = 3'd0,
        A_COUNT = 3'd1,
        A_CTRL  = 3'd2,
        A_ICLR  = 3'd3,
        A_CAPT  = 3'd4
    } addr_e;

    typedef struct packed {
        logic [PS_W-1:0]   ps_val;
        logic              ps_en;
        logic              irq_from_ps;
        logic              cap_en;
        logic [SEL_W-1:0]  cap_sel;
        logic [TSEL_W-1:0] tick_sel;
        logic              up;
        logic              run;
        logic              periodic;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{ps_val: 8'd1, default: '0};

    function automatic logic [PS_W-1:0] ps_fix(input logic [PS_W-1:0] v);
        return (v == '0) ? PS_W'(1) : v;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.ps_val      = ps_fix(w[31:24]);
        c.ps_en       = w[23];
        c.irq_from_ps = w[18];
        c.cap_en      = w[17];
        c.cap_sel     = w[16:12];
        c.tick_sel    = w[10:9];
        c.up          = w[8];
        c.run         = w[7];
        c.periodic    = w[6];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c,
                                                   input logic [PS_W-1:0] ps_now,
                                                   input logic flag);
        logic [REG_W-1:0] w;
        w        = '0;
        w[31:24] = ps_now;
        w[23]    = c.ps_en;
        w[19]    = flag;
        w[18]    = c.irq_from_ps;
        w[17]    = c.cap_en;
        w[16:12] = c.cap_sel;
        w[10:9]  = c.tick_sel;
        w[8]     = c.up;
        w[7]     = c.run;
        w[6]     = c.periodic;
        return w;
    endfunction

endpackage

// File: rtl/gpt_ctrl_reg.sv
module gpt_ctrl_reg
    import gpt_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output ctrl_t             ctrl_q,
    output logic [DW-1:0]     load_q,
    output logic              ctrl_wr,
    output logic              load_wr,
    output logic              clr_wr
);

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign load_wr = wr_en && (wr_addr == A_LOAD);
    assign clr_wr  = wr_en && (wr_addr == A_ICLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            load_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= unpack_ctrl(REG_W'(wr_data));
            if (load_wr) load_q <= wr_data;
        end
    end

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter
    import gpt_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              up,
    input  logic              periodic,
    input  logic [TSEL_W-1:0] tick_sel,
    input  logic [TSRC_N-1:0] tick_in,
    input  logic              load_wr,
    input  logic [DW-1:0]     load_new,
    input  logic [DW-1:0]     load_q,
    output logic [DW-1:0]     cnt_q,
    output logic              period_end
);

    logic tick;
    logic at_end;

    assign tick = run && tick_in[tick_sel];

    always_comb begin
        if (up) at_end = periodic ? (cnt_q == load_q) : (cnt_q == '1);
        else    at_end = (cnt_q == '0);
    end

    assign period_end = tick && at_end && !load_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_wr) begin
            cnt_q <= load_new;
        end else if (tick) begin
            if (up)
                cnt_q <= (periodic && at_end) ? '0 : cnt_q + 1'b1;
            else
                cnt_q <= (periodic && at_end) ? load_q : cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/gpt_postscaler.sv
module gpt_postscaler
    import gpt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ps_en,
    input  logic [PS_W-1:0] ps_val,
    input  logic            ctrl_wr,
    input  logic [PS_W-1:0] ps_new,
    input  logic            clr_wr,
    input  logic            period_end,
    output logic [PS_W-1:0] ps_cnt,
    output logic            ps_flag,
    output logic            ps_hit
);

    assign ps_hit = ps_en && period_end && (ps_cnt == PS_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_cnt  <= PS_W'(1);
            ps_flag <= 1'b0;
        end else begin
            if (ps_hit)      ps_flag <= 1'b1;
            else if (clr_wr) ps_flag <= 1'b0;

            if (ctrl_wr)                 ps_cnt <= ps_fix(ps_new);
            else if (clr_wr || ps_hit)   ps_cnt <= ps_val;
            else if (ps_en && period_end) ps_cnt <= ps_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/gpt_capture.sv
module gpt_capture
    import gpt_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int NEV = EVT_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NEV-1:0]   evt_in,
    input  logic             cap_en,
    input  logic [SEL_W-1:0] cap_sel,
    input  logic [DW-1:0]    cnt,
    output logic [DW-1:0]    cap_q
);

    logic [NEV-1:0] s1, s2, s3;
    logic [NEV-1:0] fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= evt_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    for (genvar i = 0; i < NEV; i++) begin : g_sel
        assign fire[i] = s2[i] && !s3[i] && (32'(cap_sel) == i);
    end

    always_ff @(posedge clk) begin
        if (rst)                  cap_q <= '0;
        else if (cap_en && |fire) cap_q <= cnt;
    end

endmodule

// File: rtl/gp_timer_pcap.sv
module gp_timer_pcap
    import gpt_pkg::*;
#(
    parameter int DW  = REG_W,
    parameter int NEV = EVT_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic [TSRC_N-1:0] tick_in,
    input  logic [NEV-1:0]    evt_in,
    output logic              irq
);

    ctrl_t           ctrl_q;
    logic [DW-1:0]   load_q;
    logic [DW-1:0]   cnt_q;
    logic [DW-1:0]   cap_q;
    logic            ctrl_wr, load_wr, clr_wr;
    logic            period_end;
    logic [PS_W-1:0] ps_cnt;
    logic            ps_flag, ps_hit;
    logic            irq_set;
    logic            irq_q;

    gpt_ctrl_reg #(.DW(DW)) u_regs (
        .clk, .rst, .wr_en, .wr_addr, .wr_data,
        .ctrl_q, .load_q, .ctrl_wr, .load_wr, .clr_wr
    );

    gpt_counter #(.DW(DW)) u_cnt (
        .clk, .rst,
        .run(ctrl_q.run), .up(ctrl_q.up), .periodic(ctrl_q.periodic),
        .tick_sel(ctrl_q.tick_sel), .tick_in,
        .load_wr, .load_new(wr_data), .load_q,
        .cnt_q, .period_end
    );

    gpt_postscaler u_ps (
        .clk, .rst,
        .ps_en(ctrl_q.ps_en), .ps_val(ctrl_q.ps_val),
        .ctrl_wr, .ps_new(wr_data[31:24]),
        .clr_wr, .period_end,
        .ps_cnt, .ps_flag, .ps_hit
    );

    gpt_capture #(.DW(DW), .NEV(NEV)) u_cap (
        .clk, .rst, .evt_in,
        .cap_en(ctrl_q.cap_en), .cap_sel(ctrl_q.cap_sel),
        .cnt(cnt_q), .cap_q
    );

    assign irq_set = ctrl_q.irq_from_ps ? ps_hit : period_end;

    always_ff @(posedge clk) begin
        if (rst)          irq_q <= 1'b0;
        else if (irq_set) irq_q <= 1'b1;
        else if (clr_wr)  irq_q <= 1'b0;
    end

    assign irq = irq_q;

    always_comb begin
        case (rd_addr)
            A_LOAD:  rd_data = load_q;
            A_COUNT: rd_data = cnt_q;
            A_CTRL:  rd_data = DW'(pack_ctrl(ctrl_q, ps_cnt, ps_flag));
            A_CAPT:  rd_data = cap_q;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpt_sva.sv
module gpt_sva
    import gpt_pkg::*;
#(
    parameter int DW = REG_W
) (
    input logic              clk,
    input logic              rst,
    input ctrl_t             ctrl,
    input logic [DW-1:0]     cnt,
    input logic [DW-1:0]     cap,
    input logic [TSRC_N-1:0] tick_in,
    input logic              load_wr,
    input logic              clr_wr,
    input logic              period_end,
    input logic              irq,
    input logic              ps_flag,
    input logic [PS_W-1:0]   ps_cnt
);

    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl.ps_val == 8'd1 && !ctrl.run && cnt == '0 && cap == '0 && !irq)); // R1

    AST_PS_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctrl.ps_val != '0 && ps_cnt != '0); // R2

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !load_wr) |=> $stable(cnt)); // R3

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && tick_in[ctrl.tick_sel] && !ctrl.up && cnt != '0 && !load_wr)
        |=> cnt == $past(cnt) - 1'b1); // R4

    AST_TIMER_IRQ: assert property (@(posedge clk) disable iff (rst)
        (period_end && !ctrl.irq_from_ps) |=> irq); // R6

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !period_end) |=> (!irq && !ps_flag)); // R8

    AST_CAPTURE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ctrl.cap_en |=> $stable(cap)); // R10

endmodule

bind gp_timer_pcap gpt_sva #(.DW(DW)) u_sva (
    .clk(clk), .rst(rst), .ctrl(ctrl_q), .cnt(cnt_q), .cap(cap_q),
    .tick_in(tick_in), .load_wr(load_wr), .clr_wr(clr_wr),
    .period_end(period_end), .irq(irq_q), .ps_flag(ps_flag), .ps_cnt(ps_cnt)
);

// File: tb/gp_timer_pcap_test.sv
module gp_timer_pcap_test;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IQ = 2'd3;
    localparam int NV = 60;
    localparam int VW = 2 + 3 + 32 + 32 + 4;

    // vector: op, addr, data (for ticks: [1:0] source, [15:8] count), expected, requirement
    localparam logic [VW-1:0] VEC [NV] = '{
        {OP_RD, 3'd2, 32'h0, 32'h01000000, 4'd1},   // R1 control reset value
        {OP_RD, 3'd1, 32'h0, 32'h00000000, 4'd1},   // R1 count reset
        {OP_RD, 3'd4, 32'h0, 32'h00000000, 4'd1},   // R1 capture reset
        {OP_IQ, 3'd0, 32'h0, 32'h00000000, 4'd1},   // R1 irq low
        {OP_WR, 3'd0, 32'h3, 32'h0, 4'd3},          // R3 load 3
        {OP_RD, 3'd1, 32'h0, 32'h00000003, 4'd3},
        {OP_WR, 3'd2, 32'h000000C0, 32'h0, 4'd2},   // R2 ps field 0
        {OP_RD, 3'd2, 32'h0, 32'h010000C0, 4'd2},
        {OP_TK, 3'd0, 32'h100, 32'h0, 4'd3},
        {OP_RD, 3'd1, 32'h0, 32'h00000002, 4'd3},
        {OP_TK, 3'd0, 32'h201, 32'h0, 4'd3},        // R3 unselected source
        {OP_RD, 3'd1, 32'h0, 32'h00000002, 4'd3},
        {OP_TK, 3'd0, 32'h200, 32'h0, 4'd5},
        {OP_RD, 3'd1, 32'h0, 32'h00000000, 4'd5},
        {OP_IQ, 3'd0, 32'h0, 32'h00000000, 4'd6},
        {OP_TK, 3'd0, 32'h100, 32'h0, 4'd5},        // R5 down reload
        {OP_RD, 3'd1, 32'h0, 32'h00000003, 4'd5},
        {OP_IQ, 3'd0, 32'h0, 32'h00000001, 4'd6},   // R6
        {OP_WR, 3'd3, 32'h0, 32'h0, 4'd8},          // R8 clear
        {OP_IQ, 3'd0, 32'h0, 32'h00000000, 4'd8},
        {OP_RD, 3'd3, 32'h0, 32'h00000000, 4'd8},
        {OP_WR, 3'd0, 32'hFFFFFFFE, 32'h0, 4'd4},
        {OP_WR, 3'd2, 32'h00000580, 32'h0, 4'd4},   // R4 up, free, source 2
        {OP_TK, 3'd0, 32'h102, 32'h0, 4'd4},
        {OP_RD, 3'd1, 32'h0, 32'hFFFFFFFF, 4'd4},
        {OP_IQ, 3'd0, 32'h0, 32'h00000000, 4'd6},
        {OP_TK, 3'd0, 32'h102, 32'h0, 4'd4},
        {OP_RD, 3'd1, 32'h0, 32'h00000000, 4'd4},   // R4 up wrap
        {OP_IQ, 3'd0, 32'h0, 32'h00000001, 4'd6},
        {OP_WR, 3'd3, 32'h0, 32'h0, 4'd8},
        {OP_WR, 3'd0, 32'h2, 32'h0, 4'd5},
        {OP_WR, 3'd2, 32'h000001C0, 32'h0, 4'd5},   // R5 up periodic
        {OP_TK, 3'd0, 32'h100, 32'h0, 4'd5},
        {OP_RD, 3'd1, 32'h0, 32'h00000000, 4'd5},
        {OP_TK, 3'd0, 32'h200, 32'h0, 4'd5},
        {OP_RD, 3'd1, 32'h0, 32'h00000002, 4'd5},
        {OP_WR, 3'd3, 32'h0, 32'h0, 4'd8},
        {OP_IQ, 3'd0, 32'h0, 32'h00000000, 4'd8},
        {OP_WR, 3'd2, 32'h038401C0, 32'h0, 4'd7},   // R7 postscaler 3
        {OP_RD, 3'd2, 32'h0, 32'h038401C0, 4'd7},
        {OP_TK, 3'd0, 32'h400, 32'h0, 4'd7},
        {OP_RD, 3'd2, 32'h0, 32'h018401C0, 4'd2},   // R2 live ps count
        {OP_IQ, 3'd0, 32'h0, 32'h00000000, 4'd7},
        {OP_TK, 3'd0, 32'h300, 32'h0, 4'd7},
        {OP_RD, 3'd2, 32'h0, 32'h038C01C0, 4'd7},   // R7 flag and restart
        {OP_IQ, 3'd0, 32'h0, 32'h00000001, 4'd7},
        {OP_WR, 3'd3, 32'h0, 32'h0, 4'd8},
        {OP_RD, 3'd2, 32'h0, 32'h038401C0, 4'd8},   // R8 flag cleared
        {OP_IQ, 3'd0, 32'h0, 32'h00000000, 4'd8},
        {OP_WR, 3'd0, 32'h0, 32'h0, 4'd4},
        {OP_WR, 3'd2, 32'h00000080, 32'h0, 4'd4},   // R4 down free
        {OP_TK, 3'd0, 32'h100, 32'h0, 4'd4},
        {OP_RD, 3'd1, 32'h0, 32'hFFFFFFFF, 4'd4},
        {OP_IQ, 3'd0, 32'h0, 32'h00000001, 4'd6},
        {OP_WR, 3'd3, 32'h0, 32'h0, 4'd8},
        {OP_WR, 3'd2, 32'h00000000, 32'h0, 4'd3},   // R3 stop
        {OP_RD, 3'd2, 32'h0, 32'h01000000, 4'd2},
        {OP_TK, 3'd0, 32'h300, 32'h0, 4'd3},
        {OP_RD, 3'd1, 32'h0, 32'hFFFFFFFF, 4'd3},
        {OP_RD, 3'd0, 32'h0, 32'h00000000, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  tick_in = '0;
    logic [17:0] evt_in = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gp_timer_pcap uut (
        .clk, .rst, .wr_en, .wr_addr, .wr_data,
        .rd_addr, .rd_data, .tick_in, .evt_in, .irq
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input string req, input logic [31:0] exp);
        @(negedge clk);
        rd_addr = a;
        #0.5;
        check(req, rd_data, exp);
    endtask

    task automatic ticks(input int src, input int n);
        @(negedge clk);
        tick_in = 4'(1 << src);
        repeat (n) @(negedge clk);
        tick_in = '0;
    endtask

    task automatic pulse_evt(input logic [17:0] m);
        @(negedge clk);
        evt_in = m;
        repeat (3) @(negedge clk);
        evt_in = '0;
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec %0d", v[3:0], i);
            case (v[VW-1 -: 2])
                OP_WR: wr(v[VW-3 -: 3], v[67:36]);
                OP_RD: rd(v[VW-3 -: 3], tag, v[35:4]);
                OP_TK: ticks(int'(v[37:36]), int'(v[51:44]));
                default: begin
                    @(negedge clk);
                    check(tag, {31'b0, irq}, v[35:4]);
                end
            endcase
        end

        // R9: capture on selected event with the timer stopped
        wr(3'd0, 32'h00001234);
        wr(3'd2, 32'h00025000);
        pulse_evt(18'h00020);
        rd(3'd4, "R9 capture index 5", 32'h00001234);
        wr(3'd0, 32'h00000055);
        pulse_evt(18'h00020);
        rd(3'd4, "R9 second capture", 32'h00000055);

        // R10: unselected event, out-of-range index, capture disabled
        wr(3'd0, 32'h00000077);
        pulse_evt(18'h00010);
        rd(3'd4, "R10 unselected event", 32'h00000055);
        wr(3'd2, 32'h00034000);
        pulse_evt(18'h3FFFF);
        rd(3'd4, "R10 index 20", 32'h00000055);
        wr(3'd2, 32'h00005000);
        pulse_evt(18'h00020);
        rd(3'd4, "R10 capture disabled", 32'h00000055);
        wr(3'd2, 32'h00031000);
        pulse_evt(18'h20000);
        rd(3'd4, "R9 highest index 17", 32'h00000077);

        // R8: clear and period end in the same cycle, period end wins
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h00000080);
        @(negedge clk);
        tick_in = 4'b0001; wr_en = 1'b1; wr_addr = 3'd3; wr_data = '0;
        @(negedge clk);
        tick_in = '0; wr_en = 1'b0;
        check("R8 set beats clear", {31'b0, irq}, 32'd1);

        // R1: reset from a busy state
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(3'd2, "R1 ctrl after reset", 32'h01000000);
        rd(3'd1, "R1 count after reset", 32'h0);
        rd(3'd4, "R1 capture after reset", 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'd0);

        finish_run();
    end

endmodule